// File: doc/BRIEF.md
# Write-Progress Read Gating Synchronizer

Two masters share one frame buffer. A capture engine writes into it from the lowest address to the highest, and an encoder reads it back while the frame is still arriving. This block sits on the reader's read-address channel and snoops the writer's write-address and write-response handshakes. From those it keeps a fill mark: the number of bytes from the buffer base that are known to be written. A reader burst goes downstream only when its last byte lies below that mark. If it does not, the block holds the request, and it releases it once later writes reach far enough.

The fill mark moves only when a write burst completes with an OKAY response and that burst starts exactly at the current mark. A pulse at the start of a frame sets the mark back to zero. When the mark reaches the configured buffer size, every read passes until the next frame-start pulse. A stall flag and a stall-cycle counter show when the reader is being held back. The data channels of both masters do not go through this block.

Top module: `wr_progress_rd_gate`

## Requirements
- R1: After reset, fill_mark is 0, full_o is 0, stall_o is 0 and stall_cnt is 0.
- R2: A write response handshake with bresp = 2'b00 (OKAY), for the oldest outstanding write burst, advances fill_mark by (awlen+1)*BEAT_BYTES in the next cycle. That burst's awaddr must equal cfg_base + fill_mark.
- R3: A write response with any bresp other than 2'b00 leaves fill_mark unchanged.
- R4: A successful write response whose burst does not start at cfg_base + fill_mark leaves fill_mark unchanged.
- R5: A read whose last byte, rd_araddr + (rd_arlen+1)*BEAT_BYTES - 1, is below cfg_base + fill_mark passes in the same cycle. In that case mem_arvalid = rd_arvalid, rd_arready = mem_arready, and mem_araddr and mem_arlen equal rd_araddr and rd_arlen.
- R6: A read whose last byte is at or above cfg_base + fill_mark is held while full_o is 0. While it is held, mem_arvalid is 0, rd_arready is 0 and stall_o is 1.
- R7: stall_cnt increases by one for each clock cycle in which stall_o is 1, and holds at its maximum value of 2^CNT_W-1.
- R8: A frame_start pulse sets fill_mark to 0 in the next cycle and takes priority over a write response in the same cycle. Reads above cfg_base are then held again.
- R9: While fill_mark >= cfg_size, full_o is 1 and every read passes without a stall.
- R10: A held read is released in the cycle after the write response that covers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Byte address of the shared buffer |
| cfg_size | input | ADDR_W | Buffer size in bytes |
| frame_start | input | 1 | One-cycle pulse that restarts tracking |
| wr_awvalid | input | 1 | Snooped writer address valid |
| wr_awready | input | 1 | Snooped writer address ready |
| wr_awaddr | input | ADDR_W | Snooped writer burst start address |
| wr_awlen | input | LEN_W | Snooped writer burst length minus one |
| wr_bvalid | input | 1 | Snooped writer response valid |
| wr_bready | input | 1 | Snooped writer response ready |
| wr_bresp | input | 2 | Snooped writer response code |
| rd_arvalid | input | 1 | Reader address valid |
| rd_arready | output | 1 | Ready returned to the reader |
| rd_araddr | input | ADDR_W | Reader burst start address |
| rd_arlen | input | LEN_W | Reader burst length minus one |
| mem_arvalid | output | 1 | Gated address valid toward memory |
| mem_arready | input | 1 | Memory address ready |
| mem_araddr | output | ADDR_W | Forwarded read address |
| mem_arlen | output | LEN_W | Forwarded read length |
| stall_o | output | 1 | A read is being held this cycle |
| stall_cnt | output | CNT_W | Saturating count of stalled cycles |
| fill_mark | output | ADDR_W | Bytes known written from cfg_base |
| full_o | output | 1 | Fill mark has reached cfg_size |

## Verification
The reads tried end well inside the filled region, end exactly one byte below the mark, cross the mark by a few bytes, or lie wholly above it. These cases separate a correct less-than comparison from a less-or-equal comparison and from a comparison that uses the start address instead of the last byte. The write patterns are an in-order OKAY burst, an error response, and a burst that completes before its predecessor. These show that only successful, contiguous progress moves the mark. A read held across a covering write, a frame-start pulse that coincides with a response, and a fill up to the buffer size show release timing, reset priority and the free-pass state.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   localparam logic [1:0] RESP_OKAY = 2'b00;

   function automatic int unsigned log2_ceil(input int unsigned v);
      int unsigned r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/wpg_burst_fifo.sv
module wpg_burst_fifo #(
   parameter int unsigned WIDTH = 40,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("wpg_burst_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic             vld_q;
      logic [WIDTH-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
         end else begin
            if (push && (!vld_q || pop)) begin
               vld_q  <= 1'b1;
               data_q <= din;
            end else if (pop) begin
               vld_q  <= 1'b0;
            end
         end
      end
      assign dout  = data_q;
      assign empty = !vld_q;
   end else begin : g_ring
      localparam int unsigned PTR_W = wpg_pkg::log2_ceil(DEPTH);
      localparam int unsigned CNT_W = wpg_pkg::log2_ceil(DEPTH + 1);
      localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
      localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

      logic [WIDTH-1:0] mem [DEPTH];
      logic [PTR_W-1:0] wr_ptr, rd_ptr;
      logic [CNT_W-1:0] count;
      logic             do_push, do_pop;

      assign do_pop  = pop && (count != '0);
      assign do_push = push && ((count != CAP) || do_pop);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
         end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wr_ptr] <= din;
      end

      assign dout  = mem[rd_ptr];
      assign empty = (count == '0);
   end
endmodule

// File: rtl/wpg_watermark.sv
module wpg_watermark #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned BEAT_BYTES = 16,
   parameter int unsigned OUTSTAND   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic              frame_start,
   input  logic              aw_fire,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [LEN_W-1:0]  aw_len,
   input  logic              b_fire,
   input  logic [1:0]        b_resp,
   output logic [ADDR_W-1:0] mark,
   output logic              full
);
   localparam int unsigned BEAT_SH = wpg_pkg::log2_ceil(BEAT_BYTES);
   localparam int unsigned ENT_W   = ADDR_W + LEN_W;

   logic [ENT_W-1:0]  head;
   logic              q_empty;
   logic [ADDR_W-1:0] head_addr;
   logic [LEN_W-1:0]  head_len;
   logic [ADDR_W-1:0] head_bytes;
   logic              retire, contiguous, advance;
   logic [ADDR_W-1:0] mark_q;

   assign retire = b_fire && !q_empty;

   wpg_burst_fifo #(.WIDTH(ENT_W), .DEPTH(OUTSTAND)) u_awq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (aw_fire),
      .din   ({aw_addr, aw_len}),
      .pop   (retire),
      .dout  (head),
      .empty (q_empty)
   );

   assign {head_addr, head_len} = head;
   assign head_bytes = (ADDR_W'(head_len) + ADDR_W'(1)) << BEAT_SH;
   assign contiguous = (head_addr == cfg_base + mark_q);
   assign advance    = retire && (b_resp == wpg_pkg::RESP_OKAY) && contiguous;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mark_q <= '0;
      else if (frame_start) mark_q <= '0;
      else if (advance)     mark_q <= mark_q + head_bytes;
   end

   assign mark = mark_q;
   assign full = (mark_q >= cfg_size);
endmodule

// File: rtl/wpg_read_gate.sv
module wpg_read_gate #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned BEAT_BYTES = 16,
   parameter int unsigned CNT_W      = 16,
   parameter bit          CNT_SAT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] mark,
   input  logic              full,
   input  logic              rd_arvalid,
   output logic              rd_arready,
   input  logic [ADDR_W-1:0] rd_araddr,
   input  logic [LEN_W-1:0]  rd_arlen,
   output logic              mem_arvalid,
   input  logic              mem_arready,
   output logic [ADDR_W-1:0] mem_araddr,
   output logic [LEN_W-1:0]  mem_arlen,
   output logic              stall,
   output logic [CNT_W-1:0]  stall_cnt
);
   localparam int unsigned BEAT_SH = wpg_pkg::log2_ceil(BEAT_BYTES);

   logic [ADDR_W-1:0] last_byte, limit;
   logic              covered;
   logic [CNT_W-1:0]  cnt_q;

   assign last_byte = rd_araddr + ((ADDR_W'(rd_arlen) + ADDR_W'(1)) << BEAT_SH) - ADDR_W'(1);
   assign limit     = cfg_base + mark;
   assign covered   = full || (last_byte < limit);

   assign mem_arvalid = rd_arvalid && covered;
   assign rd_arready  = mem_arready && covered;
   assign mem_araddr  = rd_araddr;
   assign mem_arlen   = rd_arlen;
   assign stall       = rd_arvalid && !covered;

   if (CNT_SAT) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (stall && ~&cnt_q)     cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (stall) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign stall_cnt = cnt_q;
endmodule

// File: rtl/wr_progress_rd_gate.sv
module wr_progress_rd_gate #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned BEAT_BYTES = 16,
   parameter int unsigned OUTSTAND   = 4,
   parameter int unsigned CNT_W      = 16,
   parameter bit          CNT_SAT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic              frame_start,
   input  logic              wr_awvalid,
   input  logic              wr_awready,
   input  logic [ADDR_W-1:0] wr_awaddr,
   input  logic [LEN_W-1:0]  wr_awlen,
   input  logic              wr_bvalid,
   input  logic              wr_bready,
   input  logic [1:0]        wr_bresp,
   input  logic              rd_arvalid,
   output logic              rd_arready,
   input  logic [ADDR_W-1:0] rd_araddr,
   input  logic [LEN_W-1:0]  rd_arlen,
   output logic              mem_arvalid,
   input  logic              mem_arready,
   output logic [ADDR_W-1:0] mem_araddr,
   output logic [LEN_W-1:0]  mem_arlen,
   output logic              stall_o,
   output logic [CNT_W-1:0]  stall_cnt,
   output logic [ADDR_W-1:0] fill_mark,
   output logic              full_o
);
   if (BEAT_BYTES == 0 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_beat
      $error("wr_progress_rd_gate: BEAT_BYTES must be a power of two");
   end
   if (ADDR_W < 8 || LEN_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("wr_progress_rd_gate: widths out of range");
   end

   logic [ADDR_W-1:0] mark;
   logic              full;

   wpg_watermark #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .OUTSTAND(OUTSTAND)
   ) u_mark (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_base    (cfg_base),
      .cfg_size    (cfg_size),
      .frame_start (frame_start),
      .aw_fire     (wr_awvalid && wr_awready),
      .aw_addr     (wr_awaddr),
      .aw_len      (wr_awlen),
      .b_fire      (wr_bvalid && wr_bready),
      .b_resp      (wr_bresp),
      .mark        (mark),
      .full        (full)
   );

   wpg_read_gate #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES),
      .CNT_W(CNT_W), .CNT_SAT(CNT_SAT)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_base    (cfg_base),
      .mark        (mark),
      .full        (full),
      .rd_arvalid  (rd_arvalid),
      .rd_arready  (rd_arready),
      .rd_araddr   (rd_araddr),
      .rd_arlen    (rd_arlen),
      .mem_arvalid (mem_arvalid),
      .mem_arready (mem_arready),
      .mem_araddr  (mem_araddr),
      .mem_arlen   (mem_arlen),
      .stall       (stall_o),
      .stall_cnt   (stall_cnt)
   );

   assign fill_mark = mark;
   assign full_o    = full;
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              rd_arvalid,
   input logic              rd_arready,
   input logic              mem_arvalid,
   input logic              mem_arready,
   input logic              stall_o,
   input logic [CNT_W-1:0]  stall_cnt,
   input logic [ADDR_W-1:0] fill_mark,
   input logic              full_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // R6: a held read reaches neither side
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> (!mem_arvalid && !rd_arready));

   // R5: an unstalled request is forwarded with its ready returned
   p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_arvalid && !stall_o) |-> (mem_arvalid && (rd_arready == mem_arready)));

   // R8: frame start clears the mark
   p_frame_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (fill_mark == '0));

   // R2: without frame start the mark never falls
   p_mark_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> (fill_mark >= $past(fill_mark)));

   // R7: one count per stalled cycle until saturation
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && stall_cnt != CNT_MAX) |=> (stall_cnt == $past(stall_cnt) + 1'b1));

   p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_o |=> $stable(stall_cnt));

   // R9: nothing stalls once the buffer is full
   p_full_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !stall_o);
endmodule

bind wr_progress_rd_gate wpg_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .rd_arvalid  (rd_arvalid),
   .rd_arready  (rd_arready),
   .mem_arvalid (mem_arvalid),
   .mem_arready (mem_arready),
   .stall_o     (stall_o),
   .stall_cnt   (stall_cnt),
   .fill_mark   (fill_mark),
   .full_o      (full_o)
);

// File: tb/sim_wr_progress_rd_gate.sv
`timescale 1ns/1ps
module sim_wr_progress_rd_gate;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 8;
   localparam int BEAT   = 16;
   localparam int CNT_W  = 3;
   localparam logic [ADDR_W-1:0] BASE = 32'h0000_1000;
   localparam logic [ADDR_W-1:0] SIZE = 32'h0000_0400;

   logic clk = 0, rst_n = 0;
   logic [ADDR_W-1:0] cfg_base = BASE, cfg_size = SIZE;
   logic frame_start = 0;
   logic wr_awvalid = 0, wr_awready = 0, wr_bvalid = 0, wr_bready = 0;
   logic [ADDR_W-1:0] wr_awaddr = '0;
   logic [LEN_W-1:0]  wr_awlen = '0;
   logic [1:0]        wr_bresp = '0;
   logic rd_arvalid = 0, mem_arready = 1;
   logic [ADDR_W-1:0] rd_araddr = '0;
   logic [LEN_W-1:0]  rd_arlen = '0;
   logic rd_arready, mem_arvalid, stall_o, full_o;
   logic [ADDR_W-1:0] mem_araddr, fill_mark;
   logic [LEN_W-1:0]  mem_arlen;
   logic [CNT_W-1:0]  stall_cnt;

   int checks = 0, failures = 0;
   logic [ADDR_W+LEN_W-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   wr_progress_rd_gate #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT),
                         .OUTSTAND(4), .CNT_W(CNT_W), .CNT_SAT(1'b1)) u0 (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic settle();
      #1;
   endtask

   // scoreboard monitor: every forwarded handshake must match the next expected request
   always @(negedge clk) begin
      if (rst_n && mem_arvalid && mem_arready) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R5 actual=%0h expected=none (unexpected forward)", {mem_araddr, mem_arlen});
         end else begin
            logic [ADDR_W+LEN_W-1:0] e;
            e = exp_q.pop_front();
            if ({mem_araddr, mem_arlen} !== e) begin
               failures++;
               $display("FAIL R5 actual=%0h expected=%0h", {mem_araddr, mem_arlen}, e);
            end
         end
      end
   end

   task automatic rd_set(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l, input bit expect_fwd);
      rd_araddr = a; rd_arlen = l; rd_arvalid = 1;
      if (expect_fwd) exp_q.push_back({a, l});
   endtask

   task automatic rd_clear();
      rd_arvalid = 0;
   endtask

   task automatic wr_burst(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                           input logic [1:0] resp, input bit with_fs);
      wr_awaddr = a; wr_awlen = l; wr_awvalid = 1; wr_awready = 1;
      tick();
      wr_awvalid = 0; wr_awready = 0;
      wr_bvalid = 1; wr_bready = 1; wr_bresp = resp; frame_start = with_fs;
      tick();
      wr_bvalid = 0; wr_bready = 0; frame_start = 0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      settle();
      // R1 reset state
      check("R1 fill_mark", fill_mark, 0);
      check("R1 full", full_o, 0);
      check("R1 stall", stall_o, 0);
      check("R1 stall_cnt", stall_cnt, 0);
      tick();

      // R6 held at empty buffer, R7 counting
      rd_set(BASE, 8'd0, 1'b1);
      settle();
      check("R6 stall", stall_o, 1);
      check("R6 mem_arvalid", mem_arvalid, 0);
      check("R6 rd_arready", rd_arready, 0);
      repeat (3) tick();
      settle();
      check("R7 stall_cnt after 3", stall_cnt, 3);
      // R2 + R10: covering burst 256 bytes releases the held read
      wr_burst(BASE, 8'd15, 2'b00, 1'b0);
      settle();
      check("R2 fill_mark", fill_mark, 32'h100);
      check("R10 released stall", stall_o, 0);
      check("R10 released ready", rd_arready, 1);
      check("R7 stall_cnt after release", stall_cnt, 5);
      tick();
      rd_clear();

      // R5 read ending at last written byte passes
      rd_set(BASE + 32'hF0, 8'd0, 1'b1);
      settle();
      check("R5 mem_arvalid", mem_arvalid, 1);
      check("R5 mem_araddr", mem_araddr, BASE + 32'hF0);
      check("R5 stall", stall_o, 0);
      tick();
      rd_clear();

      // R6 boundary: one beat past the mark by 8 bytes
      rd_set(BASE + 32'hF8, 8'd0, 1'b0);
      settle();
      check("R6 boundary stall", stall_o, 1);
      check("R6 boundary mem_arvalid", mem_arvalid, 0);
      tick();
      rd_clear();

      // R3 error response ignored
      wr_burst(BASE + 32'h100, 8'd15, 2'b10, 1'b0);
      settle();
      check("R3 fill_mark", fill_mark, 32'h100);
      // R4 non-contiguous OKAY ignored
      wr_burst(BASE + 32'h200, 8'd15, 2'b00, 1'b0);
      settle();
      check("R4 fill_mark", fill_mark, 32'h100);
      wr_burst(BASE + 32'h100, 8'd15, 2'b00, 1'b0);
      settle();
      check("R2 second burst", fill_mark, 32'h200);

      // R7 saturation (count at 6 before, 4 more cycles)
      rd_set(BASE + 32'h300, 8'd0, 1'b0);
      repeat (4) tick();
      settle();
      check("R7 saturate", stall_cnt, 7);
      rd_clear();
      tick();

      // R9 fill up to size
      wr_burst(BASE + 32'h200, 8'd15, 2'b00, 1'b0);
      wr_burst(BASE + 32'h300, 8'd15, 2'b00, 1'b0);
      settle();
      check("R9 fill_mark", fill_mark, 32'h400);
      check("R9 full", full_o, 1);
      rd_set(BASE + 32'h3F0, 8'd15, 1'b1);
      settle();
      check("R9 pass beyond", mem_arvalid, 1);
      check("R9 no stall", stall_o, 0);
      tick();
      rd_clear();

      // R8 frame start clears, and wins over a simultaneous response
      frame_start = 1;
      tick();
      frame_start = 0;
      settle();
      check("R8 cleared", fill_mark, 0);
      check("R8 full cleared", full_o, 0);
      wr_burst(BASE, 8'd15, 2'b00, 1'b1);
      settle();
      check("R8 priority", fill_mark, 0);
      rd_set(BASE, 8'd0, 1'b0);
      settle();
      check("R8 held again", stall_o, 1);
      tick();
      rd_clear();
      tick();

      check("R5 scoreboard drained", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule